// File: doc/BRIEF.md
# Configurable Redundancy Result Voter

This block sits between a group of up to three identical accelerator copies and the read path that gathers their results. Every copy gets the same input and produces its result in the same beat. A run-time level input decides what the block does with the three words of a beat. At simplex level it forwards copy 0 unchanged. At dual level it compares copies 0 and 1. At triple level it forms a bitwise two-of-three majority. Each slot has its own saturating error counter, which is readable as a performance counter and cleared by a control pulse.

On the write side the block fans one input word out to the copies that the level enables (one, two or three). The transfer happens in the same cycle on every enabled copy, and only when all of them can take it. Both data paths use valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. The read output is held in a single register stage, so the input is ready whenever that register is empty or is being drained in the same cycle. Downstream back-pressure (out_ready low) freezes the held result until it is taken.

Top module: `tmr_vote_unit`

## Requirements
- R1: With level 0 (simplex), an accepted read beat yields out_data equal to copy 0 (in_data bits [DATA_W-1:0]) with out_err low, and no error counter changes.
- R2: With level 1 (dual), out_data is copy 0. If copies 0 and 1 differ, out_err is high for that beat and the counters of slots 0 and 1 each rise by one. Copy 2 (in_data top slice) has no effect on the output or on any counter.
- R3: With levels 2 and 3 (triple), out_data is the bitwise majority of the three copies. out_err is high when any copy differs from that result, and each slot whose word differs from it has its counter raised by one.
- R4: The result of a beat accepted at a clock edge appears on out_valid/out_data/out_err right after that edge. These outputs stay unchanged while out_valid is high and out_ready is low. in_ready equals (not out_valid) or out_ready.
- R5: Each counter is CNT_W bits wide (32 by default), rises by at most one per beat, and stays at its all-ones value once it reaches it.
- R6: A high clr_cnt at a clock edge sets every counter to zero. It wins over an increment in the same cycle.
- R7: The write enable mask is {001} for level 0, {011} for level 1 and {111} for levels 2 and 3 (bit i is copy i). wr_ready is high when every enabled copy's ready is high. cp_wr_valid equals the mask when wr_valid and wr_ready are both high, and is zero otherwise. cp_wr_data always equals wr_data.
- R8: While rst_n is low, and right after it rises, out_valid is low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| level | input | 2 | Fault-tolerance level: 0 simplex, 1 dual, 2/3 triple |
| clr_cnt | input | 1 | Clears all error counters |
| in_valid | input | 1 | Read beat from the copies is valid |
| in_ready | output | 1 | Voter can accept a read beat |
| in_data | input | 3*DATA_W | Copy i at bits [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Voted result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | DATA_W | Voted word |
| out_err | output | 1 | Disagreement seen in this beat |
| err_cnt | output | 3*CNT_W | Slot i error count at bits [i*CNT_W +: CNT_W] |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | All enabled copies ready |
| wr_data | input | DATA_W | Write word |
| cp_wr_valid | output | 3 | Per-copy write valid |
| cp_wr_ready | input | 3 | Per-copy write ready |
| cp_wr_data | output | DATA_W | Word broadcast to every copy |

## Verification
The voting path is driven with simplex beats whose three copies all differ, which shows that only copy 0 passes. Dual beats come in two kinds: equal pairs with a random copy 2, which show that copy 2 is ignored, and unequal pairs. Triple beats cover a single corrupted copy in each position, which shows that the right slot is charged, and three fully random words, which tell bitwise majority apart from any word-level choice. Random back-pressure, a clear that coincides with a failing beat, and a long run of failures against a narrow counter separate the hold, priority and saturation rules. Random copy readiness on the write side shows the all-or-none multicast for each level.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  localparam int NCOPY = 3;

  typedef enum logic [1:0] {
    LVL_SIMPLEX = 2'd0,
    LVL_DUAL    = 2'd1,
    LVL_TRIPLE  = 2'd2,
    LVL_TRIPLE2 = 2'd3
  } lvl_e;

  function automatic logic [NCOPY-1:0] copy_mask(input lvl_e lv);
    case (lv)
      LVL_SIMPLEX: copy_mask = 3'b001;
      LVL_DUAL:    copy_mask = 3'b011;
      default:     copy_mask = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/tmr_vote_core.sv
module tmr_vote_core
  import tmr_vote_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  lvl_e                    lv,
  input  logic [NCOPY*DATA_W-1:0] words,
  output logic [DATA_W-1:0]       voted,
  output logic                    disagree,
  output logic [NCOPY-1:0]        blame
);
  logic [DATA_W-1:0] w0, w1, w2, maj;

  assign w0 = words[0*DATA_W +: DATA_W];
  assign w1 = words[1*DATA_W +: DATA_W];
  assign w2 = words[2*DATA_W +: DATA_W];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign maj[b] = (w0[b] & w1[b]) | (w0[b] & w2[b]) | (w1[b] & w2[b]);
  end

  always_comb begin
    voted    = w0;
    blame    = '0;
    disagree = 1'b0;
    case (lv)
      LVL_SIMPLEX: ;
      LVL_DUAL: begin
        if (w0 != w1) begin
          disagree = 1'b1;
          blame    = 3'b011;
        end
      end
      default: begin
        voted    = maj;
        blame[0] = (w0 != maj);
        blame[1] = (w1 != maj);
        blame[2] = (w2 != maj);
        disagree = |blame;
      end
    endcase
  end
endmodule

// File: rtl/tmr_sat_counter.sv
module tmr_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  input  logic              e_in,
  input  logic              ready_dn,
  output logic              can_take,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_err
);
  assign can_take = !q_valid || ready_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_err   <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_data  <= d_in;
      q_err   <= e_in;
    end else if (ready_dn) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_vote_unit.sv
module tmr_vote_unit
  import tmr_vote_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              level,
  input  logic                    clr_cnt,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [3*DATA_W-1:0]     in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic                    out_err,
  output logic [3*CNT_W-1:0]      err_cnt,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [2:0]              cp_wr_valid,
  input  logic [2:0]              cp_wr_ready,
  output logic [DATA_W-1:0]       cp_wr_data
);
  lvl_e              lv;
  logic [DATA_W-1:0] voted;
  logic              disagree;
  logic [NCOPY-1:0]  blame;
  logic              take;
  logic [NCOPY-1:0]  mask;

  assign lv = lvl_e'(level);

  tmr_vote_core #(.DATA_W(DATA_W)) u_core (
    .lv(lv), .words(in_data), .voted(voted), .disagree(disagree), .blame(blame)
  );

  tmr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(take), .d_in(voted), .e_in(disagree),
    .ready_dn(out_ready), .can_take(in_ready), .q_valid(out_valid),
    .q_data(out_data), .q_err(out_err)
  );

  assign take = in_valid && in_ready;

  for (genvar s = 0; s < NCOPY; s++) begin : g_slot
    tmr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(take && blame[s]),
      .cnt(err_cnt[s*CNT_W +: CNT_W])
    );
  end

  // write multicast: all enabled copies move together or none does
  assign mask        = copy_mask(lv);
  assign wr_ready    = &(cp_wr_ready | ~mask);
  assign cp_wr_valid = (wr_valid && wr_ready) ? mask : '0;
  assign cp_wr_data  = wr_data;
endmodule

// File: rtl/tmr_vote_chk.sv
module tmr_vote_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          level,
  input logic                clr_cnt,
  input logic                in_valid,
  input logic                in_ready,
  input logic [3*DATA_W-1:0] in_data,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_data,
  input logic                out_err,
  input logic [3*CNT_W-1:0]  err_cnt,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [DATA_W-1:0]   wr_data,
  input logic [2:0]          cp_wr_valid,
  input logic [2:0]          cp_wr_ready,
  input logic [DATA_W-1:0]   cp_wr_data
);
  // R1
  simplex_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && level == 2'd0) |=>
      (out_valid && !out_err && out_data == $past(in_data[DATA_W-1:0])));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  // R4
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  wr_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr_valid != 3'b000) |-> (wr_valid && wr_ready && cp_wr_data == wr_data));

  // R7
  wr_triple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level[1] && cp_wr_valid != 3'b000) |-> (cp_wr_valid == 3'b111));

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt[g*CNT_W +: CNT_W] == {CNT_W{1'b1}} && !clr_cnt) |=>
        (err_cnt[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}));
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_cnt |=> (err_cnt[g*CNT_W +: CNT_W] == $past(err_cnt[g*CNT_W +: CNT_W]) ||
                    err_cnt[g*CNT_W +: CNT_W] == $past(err_cnt[g*CNT_W +: CNT_W]) + 1'b1));
    // R6
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt |=> (err_cnt[g*CNT_W +: CNT_W] == '0));
  end
endmodule

bind tmr_vote_unit tmr_vote_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tmr_vote_unit.sv
`timescale 1ns/1ps
module tb_tmr_vote_unit;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] level = 2'd0;
  logic clr_cnt = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3*DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic out_err;
  logic [3*CW-1:0] err_cnt;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic [2:0] cp_wr_valid;
  logic [2:0] cp_wr_ready = 3'b000;
  logic [DW-1:0] cp_wr_data;

  always #2.5 clk = ~clk;

  tmr_vote_unit #(.DATA_W(DW), .CNT_W(CW)) dut (.*);

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit            m_v = 0;
  logic [DW-1:0] m_d = '0;
  bit            m_e = 0;
  int            m_c [3] = '{0, 0, 0};
  string         m_tag = "R4";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] vote3(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      int n;
      n = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (n >= 2);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_v = 0; m_e = 0;
      for (int s = 0; s < 3; s++) m_c[s] = 0;
    end else begin
      bit fire;
      bit hit [3];
      logic [DW-1:0] a, b, c, r;
      fire = in_valid && (!m_v || out_ready);
      a = in_data[0 +: DW]; b = in_data[DW +: DW]; c = in_data[2*DW +: DW];
      for (int s = 0; s < 3; s++) hit[s] = 0;
      r = a;
      if (level == 2'd1) begin
        if (a != b) begin hit[0] = 1; hit[1] = 1; end
      end else if (level[1]) begin
        r = vote3(a, b, c);
        hit[0] = (a != r); hit[1] = (b != r); hit[2] = (c != r);
      end
      if (m_v && out_ready) m_v = 0;
      if (fire) begin
        m_v = 1; m_d = r; m_e = hit[0] | hit[1] | hit[2];
        m_tag = (level == 2'd0) ? "R1" : (level == 2'd1) ? "R2" : "R3";
      end
      for (int s = 0; s < 3; s++) begin
        if (clr_cnt) m_c[s] = 0;
        else if (fire && hit[s] && m_c[s] < (1 << CW) - 1) m_c[s]++;
      end
    end
  end

  task automatic check_regs();
    chk("R4 out_valid", 64'(out_valid), 64'(m_v));
    if (m_v) begin
      chk({m_tag, " out_data"}, 64'(out_data), 64'(m_d));
      chk({m_tag, " out_err"}, 64'(out_err), 64'(m_e));
    end
    for (int s = 0; s < 3; s++)
      chk("R5/R6 err_cnt", 64'(err_cnt[s*CW +: CW]), 64'(m_c[s]));
  endtask

  task automatic check_comb();
    logic [2:0] mk;
    bit rdy;
    mk = (level == 2'd0) ? 3'b001 : (level == 2'd1) ? 3'b011 : 3'b111;
    rdy = ((cp_wr_ready & mk) == mk);
    chk("R4 in_ready", 64'(in_ready), 64'(!m_v || out_ready));
    chk("R7 wr_ready", 64'(wr_ready), 64'(rdy));
    chk("R7 cp_wr_valid", 64'(cp_wr_valid), 64'((wr_valid && rdy) ? mk : 3'b000));
    chk("R7 cp_wr_data", 64'(cp_wr_data), 64'(wr_data));
  endtask

  task automatic step(input logic [1:0] lv, input bit iv, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input logic [DW-1:0] c,
                      input bit ordy, input bit clr);
    @(negedge clk);
    check_regs();
    level = lv; in_valid = iv; in_data = {c, b, a}; out_ready = ordy; clr_cnt = clr;
    wr_valid = $urandom_range(0, 1); wr_data = $urandom;
    cp_wr_ready = 3'($urandom_range(0, 7));
    #1;
    check_comb();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [DW-1:0] x, y, z;
    repeat (3) @(negedge clk);
    // R8: outputs idle and counters zero under reset
    chk("R8 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R8 err_cnt in reset", 64'(err_cnt), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after reset", 64'(out_valid), 64'd0);

    // R1 simplex with three different copies
    for (int i = 0; i < 20; i++) step(2'd0, 1, $urandom, $urandom, $urandom, 1, 0);
    // R2 dual equal pair, random copy 2
    for (int i = 0; i < 10; i++) begin x = $urandom; step(2'd1, 1, x, x, $urandom, 1, 0); end
    // R2 dual mismatch
    for (int i = 0; i < 6; i++) begin x = $urandom; step(2'd1, 1, x, ~x, x, 1, 0); end
    // R3 single corrupted copy in each position
    for (int i = 0; i < 12; i++) begin
      x = $urandom; y = x ^ (32'h1 << (i % 32));
      case (i % 3)
        0: step(2'd2, 1, y, x, x, 1, 0);
        1: step(2'd2, 1, x, y, x, 1, 0);
        default: step(2'd2, 1, x, x, y, 1, 0);
      endcase
    end
    // R6 clear wins over a coinciding failing beat
    x = $urandom;
    step(2'd2, 1, x, x, ~x, 1, 1);
    // R3 fully random words, both triple codes
    for (int i = 0; i < 10; i++) step(2'd2, 1, $urandom, $urandom, $urandom, 1, 0);
    for (int i = 0; i < 10; i++) step(2'd3, 1, $urandom, $urandom, $urandom, 1, 0);
    // R4 random back-pressure and gaps across all levels
    for (int i = 0; i < 80; i++) begin
      x = $urandom; z = (i % 4 == 0) ? $urandom : x;
      step(2'($urandom_range(0, 3)), $urandom_range(0, 1), x, (i % 5 == 0) ? ~x : x, z,
           $urandom_range(0, 1), 0);
    end
    step(2'd0, 0, 0, 0, 0, 1, 1);
    // R5 saturation of slot 2 at 15
    for (int i = 0; i < 22; i++) begin x = $urandom; step(2'd2, 1, x, x, ~x, 1, 0); end
    // R6 clear after saturation
    step(2'd0, 0, 0, 0, 0, 1, 1);
    // R7 write multicast with random copy readiness per level
    for (int i = 0; i < 24; i++) step(2'(i % 4), 0, 0, 0, 0, 1, 0);
    repeat (2) step(2'd0, 0, 0, 0, 0, 1, 0);
    finish_up();
  end
endmodule